// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block is a register-mapped set of hardware locks that lets several processors agree on who owns a shared resource. A processor asks for a semaphore by writing its 4-bit requester ID into that semaphore's word. It then reads the word back. If the owner field equals the ID it wrote, the lock is its own. Any other value means another master holds the lock. The owner frees the lock by writing zero. That release is honoured only when the requester ID on a separate sideband matches the recorded owner.

Several bus ports share the bank. Each port has an address, a write strobe, write data, a requester-ID sideband and registered read data. All writes in a cycle are judged against the state at the start of that cycle. When several ports claim the same free semaphore together, the lowest-numbered port wins. A control word selects the claim mode, and a clear-all word stands in for the interrupt-acknowledge location. Offsets that map to nothing read as zero.

Top module: `hsem_bank`

## Requirements
- R1: After reset every semaphore word and the control word read 0.
- R2: Semaphore i sits at byte offset 0x08 + 4*i. Its read data carries the owner ID in bits [3:0], and all higher bits read 0.
- R3: While control bit 0 is 0, a write whose bits [3:0] are nonzero to a free semaphore records those bits as its owner. Write data bits above [3:0] are ignored for semaphores.
- R4: A write with nonzero bits [3:0] to a held semaphore leaves the owner unchanged, whatever ID it carries.
- R5: A write with bits [3:0] equal to 0 frees a held semaphore when the port's requester-ID sideband equals the owner. The word then reads 0.
- R6: A zero write whose sideband ID differs from the owner leaves the owner unchanged.
- R7: When several ports write nonzero IDs to the same free semaphore in one cycle, the lowest-numbered port's ID is stored and the others are dropped.
- R8: Read data is registered. It shows the addressed word one cycle after the address is presented, so a write in cycle t is visible to a read addressed in cycle t+1.
- R9: The control word at offset 0x00 is a 32-bit read/write register. When several ports write it in one cycle, the lowest-numbered port wins.
- R10: While control bit 0 is 1, claim and release writes to semaphores have no effect.
- R11: The clear-all word at offset 0x90 accepts writes (normally 0xFFFF), reads 0, and changes no semaphore and no control bit.
- R12: Any other offset, including a non-word-aligned one, reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | NUM_PORTS | Per-port write strobe |
| bus_addr | input | NUM_PORTS x ADDR_W | Per-port byte address |
| bus_wdata | input | NUM_PORTS x DATA_W | Per-port write data |
| bus_mid | input | NUM_PORTS x ID_W | Per-port requester ID used to authorise releases |
| bus_rdata | output | NUM_PORTS x DATA_W | Per-port registered read data |

## Verification
The bench builds the bank with three bus ports and keeps the other parameters at their defaults. Three ports allow a same-cycle contention in which the middle port loses to port 0 but beats port 2. They also allow a write and a read of one semaphore on different ports in adjacent cycles. All 32 semaphores stay in play, so the last word at 0x84 and the gap before 0x90 are exercised. A random phase with contention on four semaphores mixes claims, rejected claims and releases with matching and mismatching IDs.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

  // Kind of location an address selects
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_CTRL = 2'd1,
    K_SEM  = 2'd2,
    K_CLR  = 2'd3
  } kind_e;

  // Fixed layout: software decodes these offsets
  localparam int unsigned CTRL_OFF = 32'h00;
  localparam int unsigned SEM_BASE = 32'h08;
  localparam int unsigned SEM_STEP = 32'h04;
  localparam int unsigned CLR_OFF  = 32'h90;

endpackage

// File: rtl/hsem_rst_sync.sv
module hsem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SEM = 32,
  parameter int IDX_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (addr == ADDR_W'(CTRL_OFF)) begin
      kind = K_CTRL;
    end else if (addr == ADDR_W'(CLR_OFF)) begin
      kind = K_CLR;
    end else begin
      for (int i = 0; i < NUM_SEM; i++) begin
        if (addr == ADDR_W'(SEM_BASE + SEM_STEP * i)) begin
          kind = K_SEM;
          idx  = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/hsem_cell.sv
module hsem_cell #(
  parameter int NUM_PORTS = 2,
  parameter int ID_W      = 4,
  parameter int IDX_W     = 5,
  parameter int MY_IDX    = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            claim_en,
  input  logic [NUM_PORTS-1:0]            port_wr,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] port_idx,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]  port_val,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]  port_mid,
  output logic [ID_W-1:0]                 owner
);

  logic [ID_W-1:0]      owner_q;
  logic [ID_W-1:0]      owner_nxt;
  logic                 owner_en;
  logic [NUM_PORTS-1:0] hit;
  logic                 claim_seen;
  logic [ID_W-1:0]      claim_id;
  logic                 release_ok;
  logic                 any_claim;
  logic                 owner_mid_hit;

  always_comb begin
    claim_seen    = 1'b0;
    claim_id      = '0;
    release_ok    = 1'b0;
    any_claim     = 1'b0;
    owner_mid_hit = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      hit[p] = port_wr[p] && (port_idx[p] == IDX_W'(MY_IDX));
      if (hit[p] && (port_val[p] != '0)) begin
        any_claim = 1'b1;
        if (!claim_seen) begin
          claim_seen = 1'b1;
          claim_id   = port_val[p];
        end
      end
      if (hit[p] && (port_val[p] == '0) && (port_mid[p] == owner_q))
        release_ok = 1'b1;
      if (hit[p] && (port_mid[p] == owner_q))
        owner_mid_hit = 1'b1;
    end
  end

  // Next state judged against the owner held at the start of the cycle
  always_comb begin
    owner_nxt = owner_q;
    if (claim_en) begin
      if (owner_q == '0) begin
        if (claim_seen) owner_nxt = claim_id;
      end else if (release_ok) begin
        owner_nxt = '0;
      end
    end
    owner_en = (owner_nxt != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= '0;
    else if (owner_en) owner_q <= owner_nxt;
  end

  assign owner = owner_q;

  // R3: a claim on a free lock in claim mode always lands
  p_claim_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && owner_q == '0 && any_claim) |=> (owner_q != '0));

  // R4: a held lock never passes straight to another owner
  p_no_steal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != '0) |=> (owner_q == '0 || $stable(owner_q)));

  // R6: without a write carrying the owner's ID, a held lock stays put
  p_foreign_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != '0 && !owner_mid_hit) |=> $stable(owner_q));

  // R10: with claim mode off the owner is frozen
  p_mode_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_en) |=> $stable(owner_q));

endmodule

// File: rtl/hsem_ctrl.sv
module hsem_ctrl #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             port_wr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] port_wdata,
  output logic [DATA_W-1:0]                ctrl
);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_nxt;
  logic              ctrl_en;

  // Walk from the top port down so the lowest port has the last word
  always_comb begin
    ctrl_nxt = ctrl_q;
    ctrl_en  = 1'b0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (port_wr[p]) begin
        ctrl_nxt = port_wdata[p];
        ctrl_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_nxt;
  end

  assign ctrl = ctrl_q;

  // R9: no write, no change
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|port_wr) |=> $stable(ctrl_q));

  // R9: port 0 always wins a control write
  p_ctrl_port0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr[0] |=> (ctrl_q == $past(port_wdata[0])));

endmodule

// File: rtl/hsem_rdport.sv
module hsem_rdport
  import hsem_pkg::*;
#(
  parameter int NUM_SEM = 32,
  parameter int ID_W    = 4,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  kind_e                         kind,
  input  logic [IDX_W-1:0]              idx,
  input  logic [NUM_SEM-1:0][ID_W-1:0]  owners,
  input  logic [DATA_W-1:0]             ctrl,
  output logic [DATA_W-1:0]             rdata
);

  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    unique case (kind)
      K_CTRL:  rdata_nxt = ctrl;
      K_SEM:   rdata_nxt = DATA_W'(owners[idx]);
      default: rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign rdata = rdata_q;

  // R12: unmapped locations read back as zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_NONE) |=> (rdata_q == '0));

  // R11: the clear-all word reads back as zero
  p_clear_word_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CLR) |=> (rdata_q == '0));

  // R2: a semaphore read never sets bits above the owner field
  p_sem_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SEM) |=> (rdata_q[DATA_W-1:ID_W] == '0));

endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SEM   = 32,
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             bus_we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] bus_addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] bus_wdata,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]   bus_mid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] bus_rdata
);

  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  logic                            rst_sync_n;
  kind_e                           kind  [NUM_PORTS];
  logic [NUM_PORTS-1:0][IDX_W-1:0] idx;
  logic [NUM_PORTS-1:0]            sem_wr;
  logic [NUM_PORTS-1:0]            ctrl_wr;
  logic [NUM_PORTS-1:0][ID_W-1:0]  sem_val;
  logic [NUM_SEM-1:0][ID_W-1:0]    owners;
  logic [DATA_W-1:0]               ctrl;
  logic                            claim_en;

  hsem_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hsem_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_SEM (NUM_SEM),
      .IDX_W   (IDX_W)
    ) i_decode (
      .addr (bus_addr[p]),
      .kind (kind[p]),
      .idx  (idx[p])
    );

    assign sem_wr[p]  = bus_we[p] && (kind[p] == K_SEM);
    assign ctrl_wr[p] = bus_we[p] && (kind[p] == K_CTRL);
    assign sem_val[p] = bus_wdata[p][ID_W-1:0];

    hsem_rdport #(
      .NUM_SEM (NUM_SEM),
      .ID_W    (ID_W),
      .IDX_W   (IDX_W),
      .DATA_W  (DATA_W)
    ) i_rdport (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .kind   (kind[p]),
      .idx    (idx[p]),
      .owners (owners),
      .ctrl   (ctrl),
      .rdata  (bus_rdata[p])
    );
  end

  hsem_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .port_wr    (ctrl_wr),
    .port_wdata (bus_wdata),
    .ctrl       (ctrl)
  );

  assign claim_en = ~ctrl[0];

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    hsem_cell #(
      .NUM_PORTS (NUM_PORTS),
      .ID_W      (ID_W),
      .IDX_W     (IDX_W),
      .MY_IDX    (s)
    ) i_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .claim_en (claim_en),
      .port_wr  (sem_wr),
      .port_idx (idx),
      .port_val (sem_val),
      .port_mid (bus_mid),
      .owner    (owners[s])
    );
  end

  // R1: nothing is held in the cycle after reset is released
  p_free_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (owners == '0 && ctrl == '0));

  // R12: writes that hit no location leave the whole bank untouched
  p_stray_write_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sem_wr == '0 && ctrl_wr == '0) |=> ($stable(owners) && $stable(ctrl)));

endmodule

// File: tb/test_hsem_bank.sv
`timescale 1ns/1ps
module test_hsem_bank;

  localparam int NP = 3;
  localparam int NS = 32;

  logic                 clk;
  logic                 rst_n;
  logic [NP-1:0]        we;
  logic [NP-1:0][7:0]   addr;
  logic [NP-1:0][31:0]  wdata;
  logic [NP-1:0][3:0]   mid;
  logic [NP-1:0][31:0]  rdata;

  int          checks;
  int          errors;
  bit          done;
  string       cur_req;
  int          m_own [NS];
  logic [31:0] m_ctrl;
  logic [31:0] exp_rd [NP];

  hsem_bank #(.NUM_PORTS(NP), .NUM_SEM(NS), .ID_W(4), .ADDR_W(8), .DATA_W(32)) i_hsem_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_mid   (mid),
    .bus_rdata (rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] model_read(int unsigned a);
    if (a % 4 != 0) return 32'h0;
    if (a == 0) return m_ctrl;
    if (a >= 8 && a < 8 + 4 * NS) return 32'(m_own[(a - 8) / 4]);
    return 32'h0;
  endfunction

  // Behavioural reference: reads see start-of-cycle state, then writes apply
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_own[i]) m_own[i] = 0;
      m_ctrl = 32'h0;
      foreach (exp_rd[p]) exp_rd[p] = 32'h0;
    end else begin
      int          old_own [NS];
      logic [31:0] old_ctrl;
      bit          taken [NS];
      bit          ctrl_set;
      old_own  = m_own;
      old_ctrl = m_ctrl;
      ctrl_set = 0;
      foreach (taken[i]) taken[i] = 0;
      for (int p = 0; p < NP; p++) exp_rd[p] = model_read(addr[p]);
      for (int p = 0; p < NP; p++) begin
        int unsigned a;
        a = addr[p];
        if (!we[p]) continue;
        if (a == 0 && !ctrl_set) begin
          m_ctrl   = wdata[p];
          ctrl_set = 1;
        end else if (a % 4 == 0 && a >= 8 && a < 8 + 4 * NS && old_ctrl[0] == 1'b0) begin
          int i;
          int v;
          i = (a - 8) / 4;
          v = int'(wdata[p][3:0]);
          if (v != 0 && old_own[i] == 0 && !taken[i]) begin
            m_own[i] = v;
            taken[i] = 1;
          end else if (v == 0 && old_own[i] != 0 && int'(mid[p]) == old_own[i]) begin
            m_own[i] = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (rdata[p] !== exp_rd[p]) begin
          errors++;
          $display("FAIL %s port %0d: rdata=%h expected %h", cur_req, p, rdata[p], exp_rd[p]);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    we = '0;
  endtask

  task automatic put(int p, int a, logic [31:0] d, int m);
    we[p]    = 1'b1;
    addr[p]  = 8'(a);
    wdata[p] = d;
    mid[p]   = 4'(m);
  endtask

  task automatic look(int p, int a);
    addr[p] = 8'(a);
  endtask

  function automatic int sem_at(int i);
    return 8 + 4 * i;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    cur_req = "R1";
    we = '0; addr = '0; wdata = '0; mid = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) step();

    // R1: every word reads 0 after reset
    for (int i = 0; i < NS; i++) begin
      look(i % NP, sem_at(i));
      step();
    end
    look(0, 0); step(); step();

    // R2/R3: claim with junk in upper bits, read back only the ID
    cur_req = "R2";
    put(1, sem_at(5), 32'hABCD_0003, 3); look(0, sem_at(5)); step();
    step(); step();
    look(0, sem_at(5) + 1); step(); step();

    cur_req = "R3";
    for (int i = 0; i < NS; i++) begin
      if (i != 5) put(i % NP, sem_at(i), 32'((i % 15) + 1), 0);
      step();
    end
    for (int i = 0; i < NS; i++) begin
      look(2, sem_at(i)); step();
    end
    step();

    // R8: write on one port, read next cycle on another
    cur_req = "R8";
    put(0, sem_at(31), 32'h0, (31 % 15) + 1); step();
    put(0, sem_at(31), 32'h9, 0); look(1, sem_at(31)); step();
    look(1, sem_at(31)); step(); step();

    // R4: claim of a held lock with another ID is dropped
    cur_req = "R4";
    put(2, sem_at(5), 32'h7, 7); look(0, sem_at(5)); step();
    look(0, sem_at(5)); step(); step();

    // R6: release with the wrong sideband ID
    cur_req = "R6";
    put(1, sem_at(5), 32'h0, 4); step();
    look(0, sem_at(5)); step(); step();

    // R5: release with the owner's ID
    cur_req = "R5";
    put(1, sem_at(5), 32'h0, 3); step();
    look(0, sem_at(5)); step(); step();

    // R7: three-way contention, then two-way
    cur_req = "R7";
    put(0, sem_at(5), 32'h7, 7); put(1, sem_at(5), 32'h9, 9); put(2, sem_at(5), 32'hB, 11); step();
    look(0, sem_at(5)); step(); step();
    put(0, sem_at(5), 32'h0, 7); step();
    put(1, sem_at(5), 32'h9, 9); put(2, sem_at(5), 32'hB, 11); step();
    look(2, sem_at(5)); step(); step();

    // R9: control word, lowest port wins
    cur_req = "R9";
    put(2, 0, 32'h1234_5678, 0); put(1, 0, 32'hCAFE_0001, 0); step();
    look(0, 0); step(); step();

    // R10: claim mode off, claims and releases do nothing
    cur_req = "R10";
    put(0, sem_at(5), 32'h0, 9); put(1, sem_at(6), 32'h2, 2); step();
    look(0, sem_at(5)); look(1, sem_at(6)); step(); step();
    put(0, 0, 32'h0, 0); step(); step();

    // R11: clear-all word
    cur_req = "R11";
    put(2, 'h90, 32'h0000_FFFF, 0); step();
    look(2, 'h90); look(0, sem_at(5)); look(1, 0); step(); step();

    // R12: unmapped and misaligned offsets
    cur_req = "R12";
    put(0, 'h04, 32'hFFFF_FFFF, 0); put(1, 'h88, 32'h5, 5); put(2, 'hFC, 32'h6, 6); step();
    look(0, 'h04); look(1, 'h88); look(2, 'h8E); step(); step();
    put(0, sem_at(6) + 2, 32'h0, 0); step();
    look(0, sem_at(6)); step(); step();

    // R7: random contention on four semaphores
    cur_req = "R7";
    for (int k = 0; k < 800; k++) begin
      for (int p = 0; p < NP; p++) begin
        int s;
        s = int'($urandom % 4);
        if ($urandom % 2 == 1)
          put(p, sem_at(s), ($urandom % 3 == 0) ? 32'h0 : 32'($urandom % 16), int'($urandom % 16));
        else
          look(p, sem_at(s));
      end
      step();
    end
    step(); step();

    finish_run();
  end

endmodule